// File: doc/BRIEF.md
# Windowed Result Watchdog

This block watches a stream of finished conversion results and raises a sticky event flag when a watched result lies outside a window bounded by a low and a high threshold. Each result arrives as a one-cycle valid pulse with its data, a channel number and a tag telling whether it came from the regular or the inserted group. The block itself produces no results.

The comparator can watch the whole regular group, the whole inserted group, or both. A single-channel mode narrows the watch to one selected channel. Configuration arrives as one-cycle commands on a small command port. The watched state (group enables, single-channel bit, channel select) is brought out as outputs. An interrupt output follows the flag when interrupts are enabled.

Top module: `awd_window_monitor`

## Requirements
- R1: After reset the flag, interrupt, both group enables, single-channel bit, channel select and interrupt enable are 0. The low threshold is 0 and the high threshold is all ones, so no result counts as an event.
- R2: Command op 4 loads the low bound from cmdLo and the high bound from cmdHi. A watched result is an event only when its data is strictly below the low bound or strictly above the high bound. A value equal to either bound is not an event.
- R3: Command op 2 sets the regular enable from cmdGroup[0] and the inserted enable from cmdGroup[1]. It clears the single-channel bit and keeps the channel select. A result with resInserted=0 is watched only while the regular enable is 1. A result with resInserted=1 is watched only while the inserted enable is 1.
- R4: Command op 1 sets the single-channel bit and both group enables, and loads the channel select from cmdChan. In that mode, only results whose resChan equals the channel select are watched.
- R5: Command op 3 clears both group enables, the single-channel bit and the channel select. After it, no result sets the flag.
- R6: The flag is 1 from the clock edge that samples a watched event result. It stays 1 through later in-window results until it is cleared.
- R7: Command op 5 clears the flag. If an event arrives in the same cycle as the clear, the flag stays 1.
- R8: Command op 6 loads the interrupt enable from cmdGroup[0]. The irq output equals flag AND interrupt enable.
- R9: Result inputs are ignored while resValid is 0. A configuration command affects results from the cycle after the command onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code (0 none, 1 single, 2 group, 3 off, 4 thresholds, 5 clear flag, 6 interrupt enable) |
| cmdChan | input | 5 | Channel for op 1 |
| cmdGroup | input | 2 | Group enables for op 2; bit 0 is the interrupt enable for op 6 |
| cmdLo | input | 12 | Low bound for op 4 |
| cmdHi | input | 12 | High bound for op 4 |
| resValid | input | 1 | Result valid pulse |
| resData | input | 12 | Result value |
| resChan | input | 5 | Result channel |
| resInserted | input | 1 | 1 for inserted group, 0 for regular |
| evtFlag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Interrupt |
| regEn | output | 1 | Regular-group watch enable |
| insEn | output | 1 | Inserted-group watch enable |
| singleMode | output | 1 | Single-channel mode bit |
| chanSel | output | 5 | Selected channel |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a watched out-of-window result. The stimulus sets an event first, then drives the clear command and a below-window result on the same cycle, and expects the flag to remain set. A second hard case is a result that arrives in the same cycle as a mode command. It is reached by issuing the disable command together with an out-of-window result: the result is judged by the old configuration. The next such result is then ignored.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int DATA_W = 12;
  localparam int CHAN_W = 5;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_SINGLE = 3'd1,
    OP_GROUP  = 3'd2,
    OP_OFF    = 3'd3,
    OP_THRESH = 3'd4,
    OP_CLEAR  = 3'd5,
    OP_IRQ    = 3'd6,
    OP_RSVD   = 3'd7
  } awd_op_e;

  typedef struct packed {
    logic loadThresh;
    logic sample;
  } awd_strobe_t;
endpackage

// File: rtl/awd_dp.sv
module awd_dp
  import awd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  awd_strobe_t       strobe,
  input  logic [DW-1:0]     newLo,
  input  logic [DW-1:0]     newHi,
  input  logic [DW-1:0]     resData,
  output logic              hit
);
  localparam logic [DW-1:0] LO_RESET = '0;
  localparam logic [DW-1:0] HI_RESET = '1;

  logic [DW-1:0] loQ;
  logic [DW-1:0] hiQ;
  logic          belowLo;
  logic          aboveHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ <= LO_RESET;
      hiQ <= HI_RESET;
    end else if (strobe.loadThresh) begin
      loQ <= newLo;
      hiQ <= newHi;
    end
  end

  always_comb begin
    belowLo = resData < loQ;
    aboveHi = resData > hiQ;
    hit     = strobe.sample && (belowLo || aboveHi);
  end
endmodule

// File: rtl/awd_ctrl.sv
module awd_ctrl
  import awd_pkg::*;
#(
  parameter int CW = CHAN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [CW-1:0] cmdChan,
  input  logic [1:0]    cmdGroup,
  input  logic          resValid,
  input  logic [CW-1:0] resChan,
  input  logic          resInserted,
  input  logic          hit,
  output awd_strobe_t   strobe,
  output logic          evtFlag,
  output logic          irq,
  output logic          regEn,
  output logic          insEn,
  output logic          singleMode,
  output logic [CW-1:0] chanSel
);
  awd_op_e op;
  logic    groupOk;
  logic    chanOk;
  logic    clearReq;
  logic    irqEn;

  always_comb begin
    op       = awd_op_e'(cmdOp);
    groupOk  = resInserted ? insEn : regEn;
    chanOk   = !singleMode || (resChan == chanSel);
    clearReq = cmdValid && (op == OP_CLEAR);
    strobe.sample     = resValid && groupOk && chanOk;
    strobe.loadThresh = cmdValid && (op == OP_THRESH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regEn      <= 1'b0;
      insEn      <= 1'b0;
      singleMode <= 1'b0;
      chanSel    <= '0;
      irqEn      <= 1'b0;
    end else if (cmdValid) begin
      case (op)
        OP_SINGLE: begin
          regEn      <= 1'b1;
          insEn      <= 1'b1;
          singleMode <= 1'b1;
          chanSel    <= cmdChan;
        end
        OP_GROUP: begin
          regEn      <= cmdGroup[0];
          insEn      <= cmdGroup[1];
          singleMode <= 1'b0;
        end
        OP_OFF: begin
          regEn      <= 1'b0;
          insEn      <= 1'b0;
          singleMode <= 1'b0;
          chanSel    <= '0;
        end
        OP_IRQ:  irqEn <= cmdGroup[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         evtFlag <= 1'b0;
    else if (hit)      evtFlag <= 1'b1;
    else if (clearReq) evtFlag <= 1'b0;
  end

  assign irq = evtFlag && irqEn;
endmodule

// File: rtl/awd_window_monitor.sv
module awd_window_monitor
  import awd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHAN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [CW-1:0] cmdChan,
  input  logic [1:0]    cmdGroup,
  input  logic [DW-1:0] cmdLo,
  input  logic [DW-1:0] cmdHi,
  input  logic          resValid,
  input  logic [DW-1:0] resData,
  input  logic [CW-1:0] resChan,
  input  logic          resInserted,
  output logic          evtFlag,
  output logic          irq,
  output logic          regEn,
  output logic          insEn,
  output logic          singleMode,
  output logic [CW-1:0] chanSel
);
  awd_strobe_t strobe;
  logic        evtHit;

  awd_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdChan(cmdChan), .cmdGroup(cmdGroup), .resValid(resValid),
    .resChan(resChan), .resInserted(resInserted), .hit(evtHit),
    .strobe(strobe), .evtFlag(evtFlag), .irq(irq), .regEn(regEn),
    .insEn(insEn), .singleMode(singleMode), .chanSel(chanSel)
  );

  awd_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newLo(cmdLo),
    .newHi(cmdHi), .resData(resData), .hit(evtHit)
  );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [2:0]    cmdOp,
  input logic [CW-1:0] cmdChan,
  input logic          resValid,
  input logic          evtHit,
  input logic          evtFlag,
  input logic          irq,
  input logic          regEn,
  input logic          insEn,
  input logic          singleMode,
  input logic [CW-1:0] chanSel
);
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evtHit |=> evtFlag); // R6
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    evtHit |-> resValid); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !(cmdValid && cmdOp == 3'd5)) |=> evtFlag); // R6
  AST_CLEAR_WINS_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd5 && !evtHit) |=> !evtFlag); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> evtFlag); // R8
  AST_SINGLE_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1) |=> (regEn && insEn && singleMode && chanSel == $past(cmdChan))); // R4
  AST_OFF_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd3) |=> (!regEn && !insEn && !singleMode && chanSel == '0)); // R5
  AST_GROUP_CLEARS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd2) |=> (!singleMode && $stable(chanSel))); // R3
endmodule

bind awd_window_monitor awd_checker #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdChan(cmdChan), .resValid(resValid), .evtHit(evtHit),
  .evtFlag(evtFlag), .irq(irq), .regEn(regEn), .insEn(insEn),
  .singleMode(singleMode), .chanSel(chanSel)
);

// File: tb/sim_awd_window_monitor.sv
module sim_awd_window_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [4:0]  cmdChan = '0;
  logic [1:0]  cmdGroup = '0;
  logic [11:0] cmdLo = '0;
  logic [11:0] cmdHi = '0;
  logic        resValid = 1'b0;
  logic [11:0] resData = '0;
  logic [4:0]  resChan = '0;
  logic        resInserted = 1'b0;
  logic        evtFlag, irq, regEn, insEn, singleMode;
  logic [4:0]  chanSel;
  int          nRun = 0;
  int          nFail = 0;

  always #5 clk = ~clk;

  awd_window_monitor u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdChan(cmdChan), .cmdGroup(cmdGroup), .cmdLo(cmdLo), .cmdHi(cmdHi),
    .resValid(resValid), .resData(resData), .resChan(resChan),
    .resInserted(resInserted), .evtFlag(evtFlag), .irq(irq),
    .regEn(regEn), .insEn(insEn), .singleMode(singleMode), .chanSel(chanSel)
  );

  // {data, channel, inserted, expected flag}
  localparam logic [18:0] VEC [8] = '{
    {12'd100,  5'd3, 1'b0, 1'b0},
    {12'd99,   5'd3, 1'b0, 1'b1},
    {12'd3000, 5'd4, 1'b0, 1'b0},
    {12'd3001, 5'd4, 1'b0, 1'b1},
    {12'd1500, 5'd9, 1'b0, 1'b0},
    {12'd0,    5'd1, 1'b0, 1'b1},
    {12'd4095, 5'd2, 1'b0, 1'b1},
    {12'd4095, 5'd2, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setCmd(input logic [2:0] op, input logic [4:0] ch, input logic [1:0] grp,
                        input logic [11:0] lo, input logic [11:0] hi);
    cmdValid = 1'b1; cmdOp = op; cmdChan = ch; cmdGroup = grp; cmdLo = lo; cmdHi = hi;
  endtask

  task automatic setRes(input logic [11:0] d, input logic [4:0] ch, input logic ins);
    resValid = 1'b1; resData = d; resChan = ch; resInserted = ins;
  endtask

  task automatic step;
    @(negedge clk);
    cmdValid = 1'b0; resValid = 1'b0;
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [4:0] ch, input logic [1:0] grp,
                       input logic [11:0] lo, input logic [11:0] hi);
    setCmd(op, ch, grp, lo, hi); step();
  endtask

  task automatic doRes(input logic [11:0] d, input logic [4:0] ch, input logic ins);
    setRes(d, ch, ins); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flag", evtFlag, 0);
    check("R1 irq", irq, 0);
    check("R1 cfg", {regEn, insEn, singleMode, chanSel}, 0);
    // R1 reset window spans the full range
    doCmd(3'd2, 5'd0, 2'b11, 0, 0);
    doRes(12'd0, 5'd0, 1'b0);
    doRes(12'd4095, 5'd0, 1'b1);
    check("R1 full window", evtFlag, 0);

    // R2/R3 table: window 100..3000, regular group only
    doCmd(3'd4, 5'd0, 2'b00, 12'd100, 12'd3000);
    doCmd(3'd2, 5'd0, 2'b01, 0, 0);
    for (int i = 0; i < 8; i++) begin
      doCmd(3'd5, 5'd0, 2'b00, 0, 0);
      doRes(VEC[i][18:7], VEC[i][6:2], VEC[i][1]);
      check($sformatf("R2 R3 vector %0d", i), evtFlag, VEC[i][0]);
    end

    // R9 invalid result ignored
    doCmd(3'd5, 5'd0, 2'b00, 0, 0);
    resData = 12'd5; resChan = 5'd3; resInserted = 1'b0; resValid = 1'b0;
    step();
    check("R9 no valid", evtFlag, 0);

    // R4 single-channel mode
    doCmd(3'd1, 5'd7, 2'b00, 0, 0);
    check("R4 cfg", {regEn, insEn, singleMode, chanSel}, {3'b111, 5'd7});
    doRes(12'd5, 5'd8, 1'b1);
    check("R4 other channel", evtFlag, 0);
    doRes(12'd5, 5'd7, 1'b1);
    check("R4 selected channel", evtFlag, 1);

    // R6 sticky through an in-window result
    doRes(12'd500, 5'd7, 1'b0);
    check("R6 sticky", evtFlag, 1);

    // R8 interrupt
    check("R8 irq off", irq, 0);
    doCmd(3'd6, 5'd0, 2'b01, 0, 0);
    check("R8 irq on", irq, 1);

    // R7 clear and event in same cycle: event wins
    setCmd(3'd5, 5'd0, 2'b00, 0, 0);
    setRes(12'd1, 5'd7, 1'b0);
    step();
    check("R7 event beats clear", evtFlag, 1);
    doCmd(3'd5, 5'd0, 2'b00, 0, 0);
    check("R7 clear", evtFlag, 0);
    check("R8 irq follows flag", irq, 0);

    // R3 group command drops single bit, keeps channel select
    doCmd(3'd2, 5'd0, 2'b10, 0, 0);
    check("R3 cfg", {regEn, insEn, singleMode, chanSel}, {3'b010, 5'd7});
    doRes(12'd1, 5'd2, 1'b1);
    check("R3 inserted any channel", evtFlag, 1);
    doCmd(3'd5, 5'd0, 2'b00, 0, 0);

    // R9 result in same cycle as disable judged by old configuration
    setCmd(3'd3, 5'd0, 2'b00, 0, 0);
    setRes(12'd1, 5'd2, 1'b1);
    step();
    check("R9 old config applies", evtFlag, 1);
    // R5 disable clears everything
    check("R5 cfg", {regEn, insEn, singleMode, chanSel}, 0);
    doCmd(3'd5, 5'd0, 2'b00, 0, 0);
    doRes(12'd1, 5'd2, 1'b1);
    doRes(12'd4095, 5'd2, 1'b0);
    check("R5 no event when off", evtFlag, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule